// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block sits on the host side of a sampling analog-to-digital converter that has a level-triggered, active-low convert input, an active-low busy output and a serial result port. The result port is a data clock plus a data line, and it is driven by the converter during each conversion. The controller issues convert pulses of a fixed width at a programmable sample period. It never issues them closer together than the converter's minimum throughput time. It collects the bits that arrive while the converter is busy.

The converter streams out the result of the previous conversion while it works on the current one. For that reason the controller drops the first completed transfer after reset. It hands over every later one when busy returns high. The word then appears on a parallel output with a one-cycle valid strobe.

All three converter lines are asynchronous to the host clock. A transfer that does not carry exactly sixteen bits is reported as a length error. A convert pulse that the converter never acknowledges by pulling busy low is reported as a timeout error. A configuration input selects whether the word leaves as two's complement or as offset binary. Offset binary is the same word with its top bit inverted.

Top module: `adc_capture_ctrl`

## Requirements
- R1: Each convert pulse drives `conv_n` low for exactly PULSE_CYC host cycles (default 8, i.e. 80 ns at 100 MHz; legal values lie between 40 ns and 12 µs).
- R2: `conv_n` is already high whenever `adc_busy` rises.
- R3: Successive falling edges of `conv_n` are spaced by exactly max(`period`, MIN_PERIOD) cycles (MIN_PERIOD default 2500 = 25 µs). The first pulse after reset, or after a long pause, starts on the first enabled cycle.
- R4: Bits are taken on rising edges of the synchronised data clock, first bit as word bit 15. When `adc_busy` rises, `word_valid` is high for one cycle in the third host clock cycle after the change, with `word` holding the sixteen bits.
- R5: The first transfer completed after reset produces neither `word_valid` nor an error strobe.
- R6: A transfer whose bit count at busy rise differs from 16 raises `err_len` for one cycle in place of `word_valid`, and `word` keeps its previous value.
- R7: If `adc_busy` is not seen low after a convert pulse, `err_tmo` pulses once, `tmo_limit`+1 cycles after `conv_n` falls (for `tmo_limit` ≥ PULSE_CYC), and no word is produced.
- R8: With `offset_bin` = 1 at completion, `word` equals the received word with bit 15 inverted; with 0 it is passed unchanged.
- R9: During reset, `conv_n` is high, `word` is 0 and all strobes are low.
- R10: `word_valid`, `err_len` and `err_tmo` are mutually exclusive and never high on two consecutive cycles.
- R11: While `en` is low no convert pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Allows new convert pulses |
| period | input | PER_W | Sample period in host cycles |
| tmo_limit | input | TMO_W | Cycles after pulse start within which busy must fall |
| offset_bin | input | 1 | 1 = output offset binary, 0 = two's complement |
| adc_busy | input | 1 | Converter busy line, low while converting (asynchronous) |
| adc_dclk | input | 1 | Converter serial data clock (asynchronous) |
| adc_sdata | input | 1 | Converter serial data (asynchronous) |
| conv_n | output | 1 | Active-low convert pulse to the converter |
| word | output | DATA_W | Last good captured word |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| err_len | output | 1 | One-cycle strobe: bit count was not 16 |
| err_tmo | output | 1 | One-cycle strobe: converter never went busy |

## Verification
The assertions check the following on every cycle:
- the exact convert pulse width;
- that the convert line is released before busy rises;
- the minimum spacing between pulse starts;
- that no pulse starts while disabled;
- that the strobes are exclusive and single-cycle;
- that the word stays put except when it is strobed valid.

Some behaviour only the bench scenarios can show. These are the exact sample period under two settings, including clamping to the minimum, and the bit order of the shifted data. They also cover the three-cycle latency from busy rising, the discarded first transfer, short and long transfers, the timeout position and the offset-binary conversion.

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int DATA_W     = 16,
  parameter int PULSE_CYC  = 8,
  parameter int MIN_PERIOD = 2500,
  parameter int PER_W      = 20,
  parameter int TMO_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PER_W-1:0]  period,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              offset_bin,
  input  logic              adc_busy,
  input  logic              adc_dclk,
  input  logic              adc_sdata,
  output logic              conv_n,
  output logic [DATA_W-1:0] word,
  output logic              word_valid,
  output logic              err_len,
  output logic              err_tmo
);
  localparam int PCW = $clog2(PULSE_CYC + 1);
  localparam int NBW = $clog2(DATA_W + 1) + 1;
  localparam logic [PER_W-1:0] MINP = PER_W'(MIN_PERIOD);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_WAIT, S_CONV} st_t;
  st_t st;

  logic [2:0] bsy_q, ck_q;
  logic [1:0] dat_q;
  logic [PCW-1:0] pcnt;
  logic [TMO_W-1:0] tcnt;
  logic [PER_W-1:0] gap;
  logic [NBW-1:0] nbits;
  logic [DATA_W-1:0] shreg;
  logic primed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bsy_q <= '1;
      ck_q  <= '0;
      dat_q <= '0;
    end else begin
      bsy_q <= {bsy_q[1:0], adc_busy};
      ck_q  <= {ck_q[1:0], adc_dclk};
      dat_q <= {dat_q[0], adc_sdata};
    end

  wire busy_s    = bsy_q[1];
  wire busy_rise = bsy_q[1] & ~bsy_q[2];
  wire dclk_rise = ck_q[1] & ~ck_q[2];
  wire [PER_W-1:0] eff_per = (period < MINP) ? MINP : period;
  wire [DATA_W-1:0] fmt = offset_bin ? {~shreg[DATA_W-1], shreg[DATA_W-2:0]} : shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      conv_n <= 1'b1;
      pcnt <= '0;
      tcnt <= '0;
      gap <= '1;
      nbits <= '0;
      shreg <= '0;
      primed <= 1'b0;
      word <= '0;
      word_valid <= 1'b0;
      err_len <= 1'b0;
      err_tmo <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      err_len <= 1'b0;
      err_tmo <= 1'b0;
      if (gap != '1) gap <= gap + 1'b1;
      if (st != S_IDLE && dclk_rise) begin
        shreg <= {shreg[DATA_W-2:0], dat_q[1]};
        if (nbits != '1) nbits <= nbits + 1'b1;
      end
      case (st)
        S_IDLE:
          if (en && gap >= eff_per) begin
            st <= S_PULSE;
            conv_n <= 1'b0;
            pcnt <= '0;
            tcnt <= '0;
            nbits <= '0;
            gap <= PER_W'(1);
          end
        S_PULSE: begin
          pcnt <= pcnt + 1'b1;
          if (tcnt != '1) tcnt <= tcnt + 1'b1;
          if (pcnt == PCW'(PULSE_CYC - 1)) begin
            conv_n <= 1'b1;
            st <= busy_s ? S_WAIT : S_CONV;
          end
        end
        S_WAIT: begin
          if (tcnt != '1) tcnt <= tcnt + 1'b1;
          if (!busy_s) st <= S_CONV;
          else if (tcnt >= tmo_limit) begin
            err_tmo <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_CONV:
          if (busy_rise) begin
            st <= S_IDLE;
            primed <= 1'b1;
            if (primed) begin
              if (nbits == NBW'(DATA_W)) begin
                word <= fmt;
                word_valid <= 1'b1;
              end else err_len <= 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/adc_capture_ctrl_sva.sv
module adc_capture_ctrl_sva #(
  parameter int DATA_W     = 16,
  parameter int PULSE_CYC  = 8,
  parameter int MIN_PERIOD = 2500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              adc_busy,
  input logic              conv_n,
  input logic [DATA_W-1:0] word,
  input logic              word_valid,
  input logic              err_len,
  input logic              err_tmo
);
  logic [31:0] lowc, gapc;
  logic c_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lowc <= '0;
      gapc <= '1;
      c_d <= 1'b1;
    end else begin
      c_d <= conv_n;
      if (conv_n) lowc <= '0;
      else if (lowc != '1) lowc <= lowc + 1;
      if (c_d && !conv_n) gapc <= 32'd1;
      else if (gapc != '1) gapc <= gapc + 1;
    end

  wire any_strobe = word_valid | err_len | err_tmo;

  assert_pulse_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> lowc == 32'(PULSE_CYC));
  assert_release_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_busy) |-> conv_n);
  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> gapc >= 32'(MIN_PERIOD));
  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word));
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_valid, err_len, err_tmo}));
  assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> !any_strobe);
  assert_enabled_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> $past(en));
endmodule

bind adc_capture_ctrl adc_capture_ctrl_sva #(
  .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC), .MIN_PERIOD(MIN_PERIOD)
) u_sva (
  .clk(clk), .rst_n(rst_n), .en(en), .adc_busy(adc_busy), .conv_n(conv_n),
  .word(word), .word_valid(word_valid), .err_len(err_len), .err_tmo(err_tmo)
);

// File: tb/adc_capture_ctrl_test.sv
module adc_capture_ctrl_test;
  localparam int PULSE = 8;
  localparam int TMO = 50;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, offset_bin = 1'b0;
  logic [19:0] period = 20'd3000;
  logic [15:0] tmo_limit = 16'(TMO);
  logic adc_busy = 1'b1, adc_dclk = 1'b0, adc_sdata = 1'b0;
  logic conv_n, word_valid, err_len, err_tmo;
  logic [15:0] word;

  adc_capture_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .tmo_limit(tmo_limit),
    .offset_bin(offset_bin), .adc_busy(adc_busy), .adc_dclk(adc_dclk),
    .adc_sdata(adc_sdata), .conv_n(conv_n), .word(word), .word_valid(word_valid),
    .err_len(err_len), .err_tmo(err_tmo)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0, nerr = 0;
  bit mon_on = 0, resync = 0, done = 0;
  int exp_per = 3000, last_fall = -1, lowrun = 0, falls = 0, nvalid = 0;
  logic prev_conv = 1'b1;
  logic [15:0] exp_w [int];
  bit exp_v [int], exp_l [int], exp_t [int];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    bit ev, el, et;
    ev = exp_v.exists(cyc);
    el = exp_l.exists(cyc);
    et = exp_t.exists(cyc);
    check(word_valid === ev, "R4/R5 word_valid", word_valid, ev);
    check(err_len === el, "R6 err_len", err_len, el);
    check(err_tmo === et, "R7 err_tmo", err_tmo, et);
    if (ev) check(word === exp_w[cyc], "R4/R8 word", word, exp_w[cyc]);
    if (word_valid === 1'b1) nvalid++;
    if (conv_n === 1'b0) lowrun++;
    if (prev_conv === 1'b1 && conv_n === 1'b0) begin
      falls++;
      check(en === 1'b1, "R11 start while disabled", 0, 1);
      if (last_fall >= 0 && !resync) check(cyc - last_fall == exp_per, "R3 spacing", cyc - last_fall, exp_per);
      resync = 0;
      last_fall = cyc;
    end
    if (prev_conv === 1'b0 && conv_n === 1'b1) begin
      check(lowrun == PULSE, "R1 pulse width", lowrun, PULSE);
      lowrun = 0;
    end
    prev_conv = conv_n;
  end

  task automatic report;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  task automatic run_conv(input logic [15:0] v, input int nb, input bit dead,
                          input bit expect_out, input bit ofs);
    int c, d;
    while (conv_n !== 1'b0) @(negedge clk);
    c = cyc;
    if (dead) begin
      exp_t[c + TMO + 1] = 1;
      repeat (TMO + 4) @(negedge clk);
      return;
    end
    repeat (2) @(negedge clk);
    adc_busy = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      adc_sdata = (i < 16) ? v[15 - i] : 1'b0;
      repeat (3) @(negedge clk);
      adc_dclk = 1'b1;
      repeat (3) @(negedge clk);
      adc_dclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(conv_n === 1'b1, "R2 convert released before busy rise", conv_n, 1);
    adc_busy = 1'b1;
    d = cyc;
    if (expect_out) begin
      if (nb == 16) begin
        exp_v[d + 3] = 1;
        exp_w[d + 3] = ofs ? {~v[15], v[14:0]} : v;
      end else exp_l[d + 3] = 1;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    check(conv_n === 1'b1, "R9 reset conv_n", conv_n, 1);
    check(word === 16'h0, "R9 reset word", word, 0);
    check({word_valid, err_len, err_tmo} === 3'b000, "R9 reset strobes", {word_valid, err_len, err_tmo}, 0);
    rst_n = 1'b1;
    en = 1'b1;
    mon_on = 1;
    run_conv(16'h2222, 16, 0, 0, 0);
    repeat (5) @(negedge clk);
    check(nvalid == 0, "R5 first transfer discarded", nvalid, 0);
    run_conv(16'h8001, 16, 0, 1, 0);
    offset_bin = 1'b1;
    run_conv(16'h1234, 16, 0, 1, 1);
    offset_bin = 1'b0;
    run_conv(16'h7FFF, 16, 0, 1, 0);
    run_conv(16'h0F0F, 15, 0, 1, 0);
    check(word === 16'h7FFF, "R6 word kept after short transfer", word, 16'h7FFF);
    run_conv(16'h3C3C, 17, 0, 1, 0);
    check(word === 16'h7FFF, "R6 word kept after long transfer", word, 16'h7FFF);
    run_conv(16'h0000, 0, 1, 1, 0);
    run_conv(16'hA5C3, 16, 0, 1, 0);
    period = 20'd100;
    exp_per = 2500;
    offset_bin = 1'b1;
    run_conv(16'h0000, 16, 0, 1, 1);
    offset_bin = 1'b0;
    en = 1'b0;
    f0 = falls;
    repeat (4000) @(negedge clk);
    check(falls == f0, "R11 no pulse while disabled", falls, f0);
    resync = 1;
    en = 1'b1;
    run_conv(16'hFFFF, 16, 0, 1, 0);
    run_conv(16'h4000, 16, 0, 1, 0);
    repeat (20) @(negedge clk);
    report();
  end
endmodule